// File: doc/BRIEF.md
# SD Card SPI-Mode Power-Up Sequencer

This block takes an SD card on a four-wire serial link from power-up to the point where the card has acknowledged its reset command and its interface-check command. A host pulses `start`. The block then produces the wake-up clock train with the card deselected. It sends the reset frame and polls for the card's one-byte status reply. After one deselected filler byte it sends the voltage-check frame, polls again, and gathers the four trailing reply bytes to confirm the echoed check pattern.

The serial engine runs in clock-polarity-0 / clock-phase-0 fashion. The serial clock idles low. Outgoing data moves only while the clock is low, and incoming data is captured on each rising clock edge after a small synchronizer. The half period of the serial clock is a run-time input, so the link can run at the slow rate needed during card initialization, or slower. When the block finishes, it pulses `done` and reports a pass or fail flag together with the last status byte it received.

Top module: `sd_spi_init`

## Requirements
- R1: While `rst` is high and after it, until `start`: `sd_cs_n`=1, `sd_sclk`=0, `sd_mosi`=1, `busy`=0, `done`=0, `err`=0, `r1`=0xFF.
- R2: `sd_sclk` has a period of 2×`half_period` system clocks. `sd_mosi` and `sd_cs_n` change only while `sd_sclk` is low. `sd_miso` is captured on the rising edges, after SYNC_STAGES flops.
- R3: After `start`, DUMMY_CLKS (default 80) serial clocks are sent with `sd_cs_n`=1 and `sd_mosi`=1, before any command.
- R4: The reset frame is sent with `sd_cs_n`=0 as the bytes 0x40 00 00 00 00 95, most significant bit first.
- R5: After each frame, the block keeps `sd_cs_n`=0 and sends 0xFF bytes. The first received byte with bit 7 clear is the status byte and is shown on `r1`. `r1` is set to 0xFF at `start`.
- R6: If POLL_LIMIT (default 8) polled bytes all have bit 7 set, the block ends with `err`=1 after exactly POLL_LIMIT poll bytes. A status byte in the last allowed poll is still accepted.
- R7: A status byte other than 0x01 ends the run with `err`=1, and no further bytes are sent.
- R8: After a 0x01 reply to the reset frame, one 0xFF byte is sent with `sd_cs_n`=1. Then the check frame 0x48 00 00 01 AA 87 is sent with `sd_cs_n`=0.
- R9: After a 0x01 reply to the check frame, four more 0xFF bytes are sent. The run ends with `err`=0 only if the fourth received byte is 0xAA.
- R10: `done` is a one-cycle pulse at the end of a run, with `busy` low and `sd_cs_n` high from that cycle on. `busy` rises only after `start`, and `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| half_period | input | DIV_W | System clocks per serial-clock half period (0 treated as 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed (timeout, bad status or bad echo) |
| r1 | output | 8 | Last status byte received |
| sd_cs_n | output | 1 | Card select, active low |
| sd_sclk | output | 1 | Serial clock to the card |
| sd_mosi | output | 1 | Serial data to the card |
| sd_miso | input | 1 | Serial data from the card |

## Verification
Each transmitted byte is final at its eighth rising serial-clock edge. The bench's scoreboard compares the select level and the byte at exactly that edge, against the item its driver queued from the requirements. `done`, `err` and `r1` are all registered together one system clock after the last byte's closing falling edge. The bench therefore waits for `done` and reads all three at the falling system-clock edge of that same cycle, then checks one cycle later that `done` has dropped. The serial-clock period is measured between two consecutive rising edges in system-clock counts. Mode-0 timing is watched at every system-clock cycle.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAKE,
      S_CMD,
      S_POLL,
      S_TAIL,
      S_GAP
   } seq_st_t;

   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [7:0] R1_IDLE   = 8'h01;
   localparam logic [7:0] ECHO_PAT  = 8'hAA;
   localparam int         FRAME_LEN = 6;
   localparam int         TAIL_LEN  = 4;

   // byte idx of the reset frame (second=0) or the voltage-check frame (second=1)
   function automatic logic [7:0] frame_byte(input logic second, input logic [2:0] idx);
      logic [7:0] b;
      b = FILL_BYTE;
      if (!second) begin
         case (idx)
            3'd0: b = 8'h40;
            3'd5: b = 8'h95;
            default: b = (idx < 3'd5) ? 8'h00 : FILL_BYTE;
         endcase
      end else begin
         case (idx)
            3'd0: b = 8'h48;
            3'd1: b = 8'h00;
            3'd2: b = 8'h00;
            3'd3: b = 8'h01;
            3'd4: b = ECHO_PAT;
            3'd5: b = 8'h87;
            default: b = FILL_BYTE;
         endcase
      end
      return b;
   endfunction

endpackage

// File: rtl/sdi_tick.sv
module sdi_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             clear,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   always_comb lim = (half == '0) ? '0 : half - DIV_W'(1);

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk) begin
      if (rst || clear) cnt <= '0;
      else if (run)     cnt <= tick ? '0 : cnt + DIV_W'(1);
   end

endmodule

// File: rtl/sdi_sync.sv
module sdi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) begin
               sr <= '1;
            end else begin
               sr[0] <= din;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sdi_shift.sv
module sdi_shift #(
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             go,
   input  logic [7:0]       tx_in,
   input  logic [DIV_W-1:0] half,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic [7:0]       rx_out,
   output logic             byte_done
);

   logic       active;
   logic       tick;
   logic       miso_s;
   logic       sclk_q;
   logic [2:0] nbit;
   logic [7:0] tx_sh;
   logic [7:0] rx_sh;

   sdi_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (active),
      .clear(go),
      .half (half),
      .tick (tick)
   );

   sdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (miso),
      .dout(miso_s)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active    <= 1'b0;
         sclk_q    <= 1'b0;
         nbit      <= '0;
         tx_sh     <= '1;
         rx_sh     <= '1;
         rx_out    <= '1;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (go) begin
            active <= 1'b1;
            tx_sh  <= tx_in;
            nbit   <= '0;
            sclk_q <= 1'b0;
         end else if (tick) begin
            if (!sclk_q) begin
               // rising edge: capture card data
               sclk_q <= 1'b1;
               rx_sh  <= {rx_sh[6:0], miso_s};
            end else begin
               // falling edge: advance outgoing data
               sclk_q <= 1'b0;
               if (nbit == 3'd7) begin
                  active    <= 1'b0;
                  byte_done <= 1'b1;
                  rx_out    <= rx_sh;
                  tx_sh     <= '1;
               end else begin
                  nbit  <= nbit + 3'd1;
                  tx_sh <= {tx_sh[6:0], 1'b1};
               end
            end
         end
      end
   end

   assign sclk = sclk_q;
   assign mosi = active ? tx_sh[7] : 1'b1;

endmodule

// File: rtl/sdi_seq.sv
module sdi_seq
   import sdi_pkg::*;
#(
   parameter int DUMMY_BYTES = 10,
   parameter int POLL_LIMIT  = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       byte_done,
   input  logic [7:0] rx_byte,
   output logic       go,
   output logic [7:0] tx_byte,
   output logic       cs_n,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic [7:0] r1
);

   localparam int MAXN = (DUMMY_BYTES > POLL_LIMIT) ?
                         ((DUMMY_BYTES > FRAME_LEN) ? DUMMY_BYTES : FRAME_LEN) :
                         ((POLL_LIMIT  > FRAME_LEN) ? POLL_LIMIT  : FRAME_LEN);
   localparam int CW = $clog2(MAXN + 1);
   localparam logic [CW-1:0] LAST_WAKE  = CW'(DUMMY_BYTES - 1);
   localparam logic [CW-1:0] LAST_POLL  = CW'(POLL_LIMIT - 1);
   localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_LEN - 1);
   localparam logic [CW-1:0] LAST_TAIL  = CW'(TAIL_LEN - 1);

   seq_st_t       st;
   logic [CW-1:0] cnt;
   logic          second;
   logic          cs_q;
   logic          go_q;
   logic [7:0]    tx_q;
   logic          done_q;
   logic          err_q;
   logic [7:0]    r1_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= S_IDLE;
         cnt    <= '0;
         second <= 1'b0;
         cs_q   <= 1'b1;
         go_q   <= 1'b0;
         tx_q   <= FILL_BYTE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         r1_q   <= FILL_BYTE;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  st     <= S_WAKE;
                  cnt    <= '0;
                  second <= 1'b0;
                  err_q  <= 1'b0;
                  r1_q   <= FILL_BYTE;
                  tx_q   <= FILL_BYTE;
                  go_q   <= 1'b1;
               end
            end
            S_WAKE: begin
               if (byte_done) begin
                  go_q <= 1'b1;
                  if (cnt == LAST_WAKE) begin
                     st   <= S_CMD;
                     cnt  <= '0;
                     cs_q <= 1'b0;
                     tx_q <= frame_byte(1'b0, 3'd0);
                  end else begin
                     cnt  <= cnt + CW'(1);
                     tx_q <= FILL_BYTE;
                  end
               end
            end
            S_CMD: begin
               if (byte_done) begin
                  go_q <= 1'b1;
                  if (cnt == LAST_FRAME) begin
                     st   <= S_POLL;
                     cnt  <= '0;
                     tx_q <= FILL_BYTE;
                  end else begin
                     cnt  <= cnt + CW'(1);
                     tx_q <= frame_byte(second, 3'(cnt + CW'(1)));
                  end
               end
            end
            S_POLL: begin
               if (byte_done) begin
                  if (!rx_byte[7]) begin
                     r1_q <= rx_byte;
                     if (rx_byte != R1_IDLE) begin
                        st     <= S_IDLE;
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                     end else if (!second) begin
                        st   <= S_GAP;
                        cs_q <= 1'b1;
                        tx_q <= FILL_BYTE;
                        go_q <= 1'b1;
                     end else begin
                        st   <= S_TAIL;
                        cnt  <= '0;
                        tx_q <= FILL_BYTE;
                        go_q <= 1'b1;
                     end
                  end else if (cnt == LAST_POLL) begin
                     st     <= S_IDLE;
                     cs_q   <= 1'b1;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     cnt  <= cnt + CW'(1);
                     tx_q <= FILL_BYTE;
                     go_q <= 1'b1;
                  end
               end
            end
            S_TAIL: begin
               if (byte_done) begin
                  if (cnt == LAST_TAIL) begin
                     st     <= S_IDLE;
                     cs_q   <= 1'b1;
                     done_q <= 1'b1;
                     err_q  <= (rx_byte != ECHO_PAT);
                  end else begin
                     cnt  <= cnt + CW'(1);
                     tx_q <= FILL_BYTE;
                     go_q <= 1'b1;
                  end
               end
            end
            S_GAP: begin
               if (byte_done) begin
                  st     <= S_CMD;
                  second <= 1'b1;
                  cnt    <= '0;
                  cs_q   <= 1'b0;
                  tx_q   <= frame_byte(1'b1, 3'd0);
                  go_q   <= 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign go      = go_q;
   assign tx_byte = tx_q;
   assign cs_n    = cs_q;
   assign busy    = (st != S_IDLE);
   assign done    = done_q;
   assign err     = err_q;
   assign r1      = r1_q;

endmodule

// File: rtl/sd_spi_init.sv
module sd_spi_init #(
   parameter int DIV_W       = 12,
   parameter int DUMMY_CLKS  = 80,
   parameter int POLL_LIMIT  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [DIV_W-1:0] half_period,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [7:0]       r1,
   output logic             sd_cs_n,
   output logic             sd_sclk,
   output logic             sd_mosi,
   input  logic             sd_miso
);

   localparam int DUMMY_BYTES = DUMMY_CLKS / 8;

   generate
      if (DUMMY_CLKS < 8 || (DUMMY_CLKS % 8) != 0) begin : g_bad_dummy
         $error("DUMMY_CLKS must be a positive multiple of 8");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
   endgenerate

   logic       go;
   logic [7:0] tx_byte;
   logic [7:0] rx_byte;
   logic       byte_done;

   sdi_shift #(
      .DIV_W      (DIV_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_shift (
      .clk      (clk),
      .rst      (rst),
      .go       (go),
      .tx_in    (tx_byte),
      .half     (half_period),
      .miso     (sd_miso),
      .sclk     (sd_sclk),
      .mosi     (sd_mosi),
      .rx_out   (rx_byte),
      .byte_done(byte_done)
   );

   sdi_seq #(
      .DUMMY_BYTES(DUMMY_BYTES),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .go       (go),
      .tx_byte  (tx_byte),
      .cs_n     (sd_cs_n),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .r1       (r1)
   );

endmodule

// File: rtl/sd_spi_init_chk.sv
module sd_spi_init_chk (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic [7:0] r1,
   input logic       cs_n,
   input logic       sclk,
   input logic       mosi
);

   // R1: when no run is active the card is deselected and the clock is parked low
   a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (cs_n && !sclk));

   // R2: outgoing data holds for the whole high phase of the serial clock
   a_r2_mosi_hold: assert property (@(posedge clk) disable iff (rst)
      sclk |-> $stable(mosi));

   // R2: select moves only while the serial clock is low
   a_r2_cs_low_clk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cs_n) |-> !sclk);

   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R10: a run begins only on request
   a_r10_start_only: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));

   // R10: once done, the block is idle and deselected
   a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && cs_n));

   // R9: a passing run always ends with the idle status byte
   a_r9_pass_status: assert property (@(posedge clk) disable iff (rst)
      (done && !err) |-> (r1 == 8'h01));

endmodule

bind sd_spi_init sd_spi_init_chk u_chk (
   .clk  (clk),
   .rst  (rst),
   .start(start),
   .busy (busy),
   .done (done),
   .err  (err),
   .r1   (r1),
   .cs_n (sd_cs_n),
   .sclk (sd_sclk),
   .mosi (sd_mosi)
);

// File: tb/sd_spi_init_bench.sv
`timescale 1ns/1ps
module sd_spi_init_bench;

   localparam int HP = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [11:0] half = 12'(HP);
   logic        busy, done, err;
   logic [7:0]  r1;
   logic        cs_n, sclk, mosi, miso;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int viol  = 0;

   logic [8:0] exp_q[$];
   logic [7:0] card_q[$];
   logic [7:0] cur = 8'hFF;
   int         cbit = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   sd_spi_init u_sd_spi_init (
      .clk(clk), .rst(rst), .start(start), .half_period(half),
      .busy(busy), .done(done), .err(err), .r1(r1),
      .sd_cs_n(cs_n), .sd_sclk(sclk), .sd_mosi(mosi), .sd_miso(miso)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // card model: drives its next bit after each falling edge while selected
   assign miso = cs_n ? 1'b1 : cur[3'(7 - cbit)];
   always @(negedge sclk) begin
      if (!cs_n) begin
         if (cbit == 7) begin
            cbit = 0;
            cur  = (card_q.size() != 0) ? card_q.pop_front() : 8'hFF;
         end else begin
            cbit++;
         end
      end
   end

   // scoreboard monitor: one item per eight rising edges
   int         rcnt = 0;
   logic [7:0] msh = 8'hFF;
   always @(posedge sclk) begin
      logic [8:0] e;
      msh = {msh[6:0], mosi};
      rcnt++;
      if (rcnt == 8) begin
         rcnt = 0;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 R7 unexpected byte", {cs_n, msh}, 0);
         end else begin
            e = exp_q.pop_front();
            chk({cs_n, msh} == e, "R3 R4 R5 R8 R9 byte stream", {cs_n, msh}, e);
         end
      end
   end

   // mode-0 watch
   logic ps = 1'b0, pm = 1'b1, pc = 1'b1;
   always @(negedge clk) begin
      if (!rst) begin
         if (ps && sclk && mosi != pm) viol++;
         if ((ps || sclk) && cs_n != pc) viol++;
      end
      ps = sclk; pm = mosi; pc = cs_n;
   end

   task automatic push_n(input bit cs, input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back({cs, b});
   endtask

   task automatic card_n(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) card_q.push_back(b);
   endtask

   task automatic run_case(input string tag, input int d0, input logic [7:0] a0,
                           input int d1, input logic [7:0] a1, input logic [7:0] t3,
                           input bit poke, input bit measure);
      logic [7:0] f0[6] = '{8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95};
      logic [7:0] f1[6] = '{8'h48, 8'h00, 8'h00, 8'h01, 8'hAA, 8'h87};
      bit         eerr;
      logic [7:0] er1;
      int         w;
      exp_q.delete();
      card_q.delete();
      eerr = 1'b0;
      er1  = 8'hFF;
      push_n(1'b1, 8'hFF, 10);                 // R3 wake clocks
      for (int i = 0; i < 6; i++) push_n(1'b0, f0[i], 1);
      card_n(8'hFF, 6);
      if (d0 >= 8) begin
         card_n(8'hFF, 8);
         push_n(1'b0, 8'hFF, 8);
         eerr = 1'b1;
      end else begin
         card_n(8'hFF, d0);
         card_n(a0, 1);
         push_n(1'b0, 8'hFF, d0 + 1);
         er1 = a0;
         if (a0 != 8'h01) begin
            eerr = 1'b1;
         end else begin
            push_n(1'b1, 8'hFF, 1);           // R8 gap byte
            for (int i = 0; i < 6; i++) push_n(1'b0, f1[i], 1);
            card_n(8'hFF, 6);
            if (d1 >= 8) begin
               push_n(1'b0, 8'hFF, 8);
               eerr = 1'b1;
            end else begin
               card_n(8'hFF, d1);
               card_n(a1, 1);
               push_n(1'b0, 8'hFF, d1 + 1);
               er1 = a1;
               if (a1 != 8'h01) begin
                  eerr = 1'b1;
               end else begin
                  card_n(8'h00, 2);
                  card_n(8'h01, 1);
                  card_n(t3, 1);
                  push_n(1'b0, 8'hFF, 4);
                  eerr = (t3 != 8'hAA);
               end
            end
         end
      end
      cur  = card_q.pop_front();
      cbit = 0;

      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy == 1'b1, {tag, " R10 busy after start"}, busy, 1);

      if (measure) fork
         begin
            int t0;
            @(posedge sclk);
            t0 = cyc;
            @(posedge sclk);
            chk((cyc - t0) == 2 * HP, "R2 serial period", cyc - t0, 2 * HP);
         end
      join_none

      if (poke) fork
         begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
         end
      join_none

      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!done && w < 20000);
      if (!done) begin
         chk(1'b0, {tag, " R10 done never seen"}, 0, 1);
         return;
      end
      chk(err == eerr, {tag, " err at done"}, err, eerr);
      chk(r1 == er1, {tag, " R5 r1 at done"}, r1, er1);
      @(negedge clk);
      chk(!done, "R10 done one cycle", done, 0);
      chk(!busy && cs_n, "R10 idle after done", {busy, cs_n}, 2'b01);
      repeat (300) @(negedge clk);
      chk(exp_q.size() == 0, {tag, " R4 stream complete"}, exp_q.size(), 0);
      chk(!busy, {tag, " R10 stray start ignored"}, busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R10 watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b1, "R1 reset lines",
          {cs_n, sclk, mosi}, 3'b101);
      chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
      chk(r1 == 8'hFF, "R1 reset status", r1, 8'hFF);

      run_case("R9 pass",          0, 8'h01, 0, 8'h01, 8'hAA, 1'b1, 1'b1);
      run_case("R6 last poll",     7, 8'h01, 3, 8'h01, 8'hAA, 1'b0, 1'b0);
      run_case("R6 reset timeout", 8, 8'h01, 0, 8'h01, 8'hAA, 1'b0, 1'b0);
      run_case("R7 bad status",    2, 8'h05, 0, 8'h01, 8'hAA, 1'b0, 1'b0);
      run_case("R7 check status",  0, 8'h01, 1, 8'h05, 8'hAA, 1'b0, 1'b0);
      run_case("R9 bad echo",      1, 8'h01, 0, 8'h01, 8'h55, 1'b0, 1'b0);
      run_case("R6 check timeout", 0, 8'h01, 8, 8'h01, 8'hAA, 1'b0, 1'b0);

      chk(viol == 0, "R2 mode-0 edge discipline", viol, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule